// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

This block is a 16-bit up-counter that advances once every four bus clocks through a fixed prescaler. An 8-bit processor reads it one half at a time through two views: a primary view and an alternate view. Reading the high half of either view parks the low half in a holding buffer. The next low-half read then returns that parked value, so the two halves belong to the same count. The full count is also driven out to a separate compare unit.

When the count wraps from all ones to zero, an overflow flag is set. While the overflow interrupt enable is high, the flag raises an interrupt request. Software clears the flag in two steps. It first reads the status byte while the flag is set, and it then reads the high half of the primary view. The alternate view gives the same data but never touches the flag, so it can be read at any time without losing an overflow.

Two small state machines carry the behaviour. The read buffer machine has the states BUF_LIVE and BUF_HELD. A high-half read moves it from live to held, and a low-half read moves it back to live. The overflow machine has the states OVF_CLEAR, OVF_PENDING and OVF_ARMED. A wrap moves it from clear, or from armed, to pending. A status read moves it from pending to armed. A primary high read moves it from armed to clear, unless a wrap happens in the same cycle, in which case it goes to pending.

Top module: `frt_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the count equals all ones minus three (0xFFFC at the default width), the overflow flag is low, the read buffer is live and the prescaler phase is zero.
- R2: While `run_en` is high, the count rises by one, modulo 2^CNT_W, on every fourth clock. While `run_en` is low, both the prescaler phase and the count hold their values.
- R3: A step of the count from all ones to zero sets the overflow flag on the same clock edge.
- R4: `irq` is high exactly when the overflow flag and `toie` are both high.
- R5: `rd_addr` selects the view and half: 0 is primary high, 1 is primary low, 2 is alternate high, 3 is alternate low. A high read returns the upper half of the current count and parks the lower half. The next low read of either view returns the parked half.
- R6: Once a half is parked, further high reads return the live upper half but do not replace the parked value. The parked value stays until a low read.
- R7: A low read made while nothing is parked returns the live lower half of the count.
- R8: A status read (`stat_rd`) made while the flag is set arms the clear. A later primary high read clears the flag. Alternate reads and primary low reads never clear it.
- R9: If a wrap and an armed primary high read fall in the same cycle, the flag stays set and the clear must be armed again.
- R10: `rd_data` is zero in any cycle in which `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enable (stands in for the oscillator start-up delay) |
| rd_en | input | 1 | Counter read strobe, one cycle per access |
| rd_addr | input | 2 | View and half select (0 primary high, 1 primary low, 2 alternate high, 3 alternate low) |
| stat_rd | input | 1 | Status byte read strobe, used to arm the flag clear |
| toie | input | 1 | Overflow interrupt enable |
| rd_data | output | CNT_W/2 | Read data for the selected half |
| count | output | CNT_W | Live count, for the compare unit |
| tof | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is the collision in R9. It needs the clear to be armed, and then a primary high read that lands on the exact clock where the prescaler's last phase meets a count of all ones. At full width that clock comes only once every 262,144 cycles. The bench therefore builds the design with an 8-bit count, so a wrap comes every 1,024 clocks. It arms the clear after one wrap, then idles while tracking its own phase and count until the wrap cycle comes round, and fires the read on that cycle. A long pseudo-random sweep over several wrap periods then mixes reads, status reads and enable changes, and checks every cycle against values worked out from the requirements.

// File: rtl/frt_pkg.sv
package frt_pkg;
    typedef enum logic {
        BUF_LIVE = 1'b0,
        BUF_HELD = 1'b1
    } buf_state_e;

    typedef enum logic [1:0] {
        OVF_CLEAR   = 2'd0,
        OVF_PENDING = 2'd1,
        OVF_ARMED   = 2'd2
    } ovf_state_e;

    typedef enum logic [1:0] {
        SEL_PRI_HI = 2'd0,
        SEL_PRI_LO = 2'd1,
        SEL_ALT_HI = 2'd2,
        SEL_ALT_LO = 2'd3
    } sel_e;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic tick
);
    localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};

    logic [PRE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (run_en)
            phase_q <= phase_q + 1'b1;
    end

    assign tick = run_en && (phase_q == LAST);

    // R2: a halted prescaler keeps its phase
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(phase_q));
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TOP   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] START = TOP - CNT_W'(3);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= START;
        else if (tick)
            count_q <= count_q + 1'b1;
    end

    assign count = count_q;
    assign wrap  = tick && (count_q == TOP);

    // R2: the count moves only on a prescaler tick, and then by exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count_q == CNT_W'($past(count_q) + 1'b1));
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_q));
    // R1: the count leaves reset at its start value
    a_r1_start: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || count_q == START));
endmodule

// File: rtl/frt_byte_latch.sv
module frt_byte_latch
    import frt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  rd_lo,
    input  logic [CNT_W-1:0]      count,
    output logic [CNT_W/2-1:0]    rd_data
);
    localparam int HALF_W = CNT_W / 2;

    buf_state_e        state_q, state_d;
    logic [HALF_W-1:0] park_q, park_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUF_LIVE;
            park_q  <= '0;
        end else begin
            state_q <= state_d;
            park_q  <= park_d;
        end
    end

    always_comb begin
        state_d = state_q;
        park_d  = park_q;
        unique case (state_q)
            BUF_LIVE: begin
                if (rd_en && !rd_lo) begin
                    state_d = BUF_HELD;
                    park_d  = count[HALF_W-1:0];
                end
            end
            BUF_HELD: begin
                if (rd_en && rd_lo)
                    state_d = BUF_LIVE;
            end
            default: state_d = BUF_LIVE;
        endcase
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (!rd_lo)
                rd_data = count[CNT_W-1:HALF_W];
            else if (state_q == BUF_HELD)
                rd_data = park_q;
            else
                rd_data = count[HALF_W-1:0];
        end
    end

    // R5: a high read from the live state parks the current lower half
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_LIVE && rd_en && !rd_lo) |=>
        (state_q == BUF_HELD && park_q == $past(count[HALF_W-1:0])));
    // R6: the parked half survives everything except a low read
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_HELD && !(rd_en && rd_lo)) |=>
        (state_q == BUF_HELD && $stable(park_q)));
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag
    import frt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic stat_rd,
    input  logic clr_req,
    output logic tof
);
    ovf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= OVF_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_CLEAR: begin
                if (wrap) state_d = OVF_PENDING;
            end
            OVF_PENDING: begin
                if (!wrap && stat_rd) state_d = OVF_ARMED;
            end
            OVF_ARMED: begin
                if (wrap)         state_d = OVF_PENDING;
                else if (clr_req) state_d = OVF_CLEAR;
            end
            default: state_d = OVF_CLEAR;
        endcase
    end

    assign tof = (state_q != OVF_CLEAR);

    // R3 and R9: a wrap always leaves the flag set
    a_r3_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> tof);
    // R8: the flag falls only after a primary high read
    a_r8_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tof) |-> $past(clr_req));
endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    input  logic               stat_rd,
    input  logic               toie,
    output logic [CNT_W/2-1:0] rd_data,
    output logic [CNT_W-1:0]   count,
    output logic               tof,
    output logic               irq
);
    logic tick;
    logic wrap;
    logic clr_req;

    frt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick)
    );

    frt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .wrap(wrap)
    );

    frt_byte_latch #(.CNT_W(CNT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_lo(rd_addr[0]),
        .count(count), .rd_data(rd_data)
    );

    assign clr_req = rd_en && (rd_addr == SEL_PRI_HI);

    frt_ovf_flag u_flag (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .stat_rd(stat_rd),
        .clr_req(clr_req), .tof(tof)
    );

    assign irq = tof && toie;
endmodule

// File: tb/frt_timer_test.sv
`timescale 1ns/1ps
module frt_timer_test;
    localparam int CW = 8;
    localparam int HW = CW / 2;
    localparam logic [CW-1:0] TOPV = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0, rd_en = 1'b0, stat_rd = 1'b0, toie = 1'b0;
    logic [1:0]    rd_addr = 2'd0;
    logic [HW-1:0] rd_data;
    logic [CW-1:0] count;
    logic          tof, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    frt_timer #(.CNT_W(CW), .PRE_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .rd_en(rd_en),
        .rd_addr(rd_addr), .stat_rd(stat_rd), .toie(toie),
        .rd_data(rd_data), .count(count), .tof(tof), .irq(irq)
    );

    // Reference state, built from the requirements
    logic [1:0]    m_ph;
    logic [CW-1:0] m_cnt;
    logic          m_tof, m_arm, m_held;
    logic [HW-1:0] m_park;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 2'd0; m_cnt <= TOPV - CW'(3);
            m_tof <= 1'b0; m_arm <= 1'b0; m_held <= 1'b0; m_park <= '0;
        end else begin : upd
            logic t, w, c;
            t = run_en && (m_ph == 2'd3);
            w = t && (m_cnt == TOPV);
            c = rd_en && (rd_addr == 2'd0);
            if (run_en) m_ph <= m_ph + 2'd1;
            if (t) m_cnt <= m_cnt + 1'b1;
            if (w) begin
                m_tof <= 1'b1; m_arm <= 1'b0;
            end else if (m_arm && c) begin
                m_tof <= 1'b0; m_arm <= 1'b0;
            end else if (m_tof && stat_rd) begin
                m_arm <= 1'b1;
            end
            if (rd_en && !rd_addr[0] && !m_held) begin
                m_held <= 1'b1; m_park <= m_cnt[HW-1:0];
            end else if (rd_en && rd_addr[0]) begin
                m_held <= 1'b0;
            end
        end
    end

    function automatic logic [HW-1:0] exp_rd();
        if (!rd_en) return '0;
        if (!rd_addr[0]) return m_cnt[CW-1:HW];
        return m_held ? m_park : m_cnt[HW-1:0];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R5 R6 R7 R10 rd_data", int'(rd_data), int'(exp_rd()));
        chk("R1 R2 count", int'(count), int'(m_cnt));
        chk("R3 R8 R9 tof", int'(tof), int'(m_tof));
        chk("R4 irq", int'(irq), int'(m_tof && toie));
    endtask

    task automatic step(input logic run, input logic ren, input logic [1:0] a,
                        input logic st, input logic ie);
        @(negedge clk);
        run_en = run; rd_en = ren; rd_addr = a; stat_rd = st; toie = ie;
        #1;
        compare_all();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R1: reset state
        repeat (3) step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R1 reset count", int'(count), int'(TOPV - CW'(3)));
        chk("R1 reset tof", int'(tof), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R1 count after release", int'(count), int'(TOPV - CW'(3)));
        // R2, R3: run to the first wrap, then hold
        repeat (20) step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R3 flag after first wrap", int'(tof), 1);
        repeat (10) step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        // R4: enable toggling
        step(1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R4 irq with enable", int'(irq), 1);
        step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        // R8: alternate reads and primary low reads do not clear
        step(1'b1, 1'b1, 2'd2, 1'b1, 1'b0);
        step(1'b1, 1'b1, 2'd3, 1'b0, 1'b0);
        step(1'b1, 1'b1, 2'd2, 1'b0, 1'b0);
        step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R8 flag kept after alt and low reads", int'(tof), 1);
        step(1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0);
        chk("R8 flag cleared by primary high", int'(tof), 0);
        // R5, R6, R7: parked reads across count steps
        step(1'b1, 1'b1, 2'd3, 1'b0, 1'b0);
        step(1'b1, 1'b1, 2'd2, 1'b0, 1'b0);
        repeat (9) step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
        repeat (5) step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 2'd3, 1'b0, 1'b0);
        // R9: arm after a wrap, then read on the next wrap cycle
        while (!m_tof) step(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 2'd0, 1'b1, 1'b1);
        while (!(m_ph == 2'd3 && m_cnt == TOPV)) step(1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 2'd0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R9 flag kept on collision", int'(tof), 1);
        step(1'b1, 1'b1, 2'd0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 2'd1, 1'b0, 1'b1);
        chk("R9 clear needs re-arming", int'(tof), 1);
        // Sweep: pseudo-random mix over several wrap periods
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:0] != 8'h00, lfsr[3] & lfsr[9], lfsr[5:4],
                 lfsr[11] & lfsr[2], lfsr[14]);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule